// File: doc/BRIEF.md
# Frame-Synced Serial Port with Start-Up Frame Rate

This block is the device side of a synchronous serial link. It makes the serial clock from the master clock and marks each outgoing 16-bit word with an output frame sync. The word goes out most significant bit first on the serial data output. On a separate serial input, with its own input frame sync from the host, it assembles incoming 16-bit words and hands each one out with a one-cycle strobe. Transmit and receive timing are independent. The host may send its words aligned with the output frames, late by any amount, or back to back.

After reset, and once the enable input goes high, output frames come at a slow start-up rate of one per 2048 master clocks. A host that is not yet configured can lock onto that rate. When a rate code is loaded, the port switches to a power-of-two frame period from the next frame boundary onward. The word to send is offered on a valid/ready input. The port asks for exactly one word at the start of each frame. Back-pressure runs one way only: if no word is valid at that moment, a frame of zeros goes out and the offered word waits for the next frame. Received words have no ready signal. The consumer must take `rx_data` in the cycle that `rx_valid` is high.

Top module: `fsync_serial_port`

## Requirements
- R1: While `en` is high, `sclk` is a square wave with a period of 4 master clocks. It is high for the first 2 cycles after each rise. The first rise comes on the first clock edge with `en` high.
- R2: `sofs` is high for exactly one serial-clock period, in the slot just before the first data bit. It changes only on a rising `sclk` edge. `sdo` also changes only on rising `sclk` edges.
- R3: The word sent in a frame appears on `sdo` most significant bit first, one bit per serial slot, in the 16 slots that follow the frame sync slot. `sdo` is 0 in the frame sync slot and in every slot after the last bit, up to the next frame.
- R4: After reset, frames start every 2048 master clocks, measured between rising edges of `sofs`.
- R5: A pulse on `rate_load` stores the code on `rate_sel`. From the first frame that starts after the current one ends, the frame period becomes 2^(7+code) master clocks: code 0 gives 128 and code 7 gives 16384.
- R6: `tx_ready` is high for one master clock, in the cycle whose closing edge starts a frame. A word is taken only when `tx_valid` is high in that cycle. If `tx_valid` is low, the frame carries all zeros.
- R7: A 1 on `sifs`, sampled on a falling `sclk` edge, makes the next 16 falling edges capture `sdi` most significant bit first. `rx_valid` is then high for exactly one master clock, right after the 16th capture, with the word on `rx_data`.
- R8: A 1 on `sifs` during the 16th bit of a word starts the next word in the very next slot. The first word is still delivered.
- R9: A 1 on `sifs` during any earlier bit abandons the partial word without a strobe, and a new word starts in the next slot.
- R10: While `en` is low, and during reset, `sclk`, `sofs`, `sdo` and `rx_valid` stay 0 and the input lines are ignored. On re-enable, a frame sync comes at the first rise, and the rate that was last applied stays in force.
- R11: Reception does not depend on the output frames. A word whose frame sync lags the output frame sync by any number of slots is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enables the serial clock and both directions |
| rate_sel | input | 3 | Frame rate code, period 2^(7+code) master clocks |
| rate_load | input | 1 | One-cycle pulse that stores `rate_sel` |
| tx_data | input | 16 | Word offered for the next frame |
| tx_valid | input | 1 | `tx_data` holds a word |
| tx_ready | output | 1 | Frame start, word taken when `tx_valid` is high |
| sdi | input | 1 | Serial data from host |
| sifs | input | 1 | Input frame sync from host |
| sclk | output | 1 | Generated serial clock |
| sofs | output | 1 | Output frame sync |
| sdo | output | 1 | Serial data to host |
| rx_data | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |

## Verification
Outgoing frames are tried under the start-up rate, the shortest, a middle and the longest programmed periods, and with `tx_valid` withdrawn. Together these separate a wrong divider or a rate applied too early from wrong bit order or a missing zero frame. Incoming words are sent aligned with the output sync, lagging it, back to back with the sync on the last bit, and cut short by an early sync. These cases distinguish a receiver that follows its own sync from one tied to transmit timing or one that miscounts bits. An enable gap in which the host keeps toggling the input lines shows whether anything leaks through while idle, and whether the rate survives re-enable.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic {
    RX_IDLE  = 1'b0,
    RX_SHIFT = 1'b1
  } rx_state_e;

  function automatic int max_log2(input int min_log2, input int sel_w);
    return min_log2 + (1 << sel_w) - 1;
  endfunction
endpackage

// File: rtl/fsp_sclk_gen.sv
module fsp_sclk_gen #(
  parameter int SCLK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int DIV = 2 * SCLK_HALF;
  localparam int CW  = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] PH_LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] PH_FALL = CW'(SCLK_HALF - 1);

  logic [CW-1:0] phase;

  assign rise = en && (phase == PH_LAST);
  assign fall = en && (phase == PH_FALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_LAST;
      sclk  <= 1'b0;
    end else if (!en) begin
      phase <= PH_LAST;
      sclk  <= 1'b0;
    end else if (rise) begin
      phase <= '0;
      sclk  <= 1'b1;
    end else begin
      phase <= phase + 1'b1;
      if (fall) sclk <= 1'b0;
    end
  end
endmodule

// File: rtl/fsp_tx.sv
module fsp_tx #(
  parameter int WORD_W   = 16,
  parameter int DIV_LOG2 = 2,
  parameter int MIN_LOG2 = 7,
  parameter int DEF_LOG2 = 11,
  parameter int SEL_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rise,
  input  logic [SEL_W-1:0]  rate_sel,
  input  logic              rate_load,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              sofs,
  output logic              sdo
);
  localparam int MAXL   = fsp_pkg::max_log2(MIN_LOG2, SEL_W);
  localparam int LOG_W  = $clog2(MAXL + 1);
  localparam int SLOT_W = MAXL - DIV_LOG2 + 1;

  logic [LOG_W-1:0]  cur_lg, pend_lg;
  logic [SLOT_W-1:0] slot, slot_last;
  logic [WORD_W-1:0] wd;

  // frame length in serial slots is 2^(log2 period - log2 divider)
  assign slot_last = (SLOT_W'(1) << (cur_lg - LOG_W'(DIV_LOG2))) - 1'b1;
  assign tx_ready  = rise && (slot == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_lg  <= LOG_W'(DEF_LOG2);
      pend_lg <= LOG_W'(DEF_LOG2);
      slot    <= '0;
      wd      <= '0;
      sofs    <= 1'b0;
      sdo     <= 1'b0;
    end else begin
      if (!en) begin
        slot <= '0;
        sofs <= 1'b0;
        sdo  <= 1'b0;
      end else if (rise) begin
        sofs <= (slot == '0);
        if (slot == '0) begin
          wd  <= tx_valid ? tx_data : '0;
          sdo <= 1'b0;
        end else if (slot <= SLOT_W'(WORD_W)) begin
          sdo <= wd[WORD_W-1];
          wd  <= wd << 1;
        end else begin
          sdo <= 1'b0;
        end
        if (slot == slot_last) begin
          slot   <= '0;
          cur_lg <= pend_lg;
        end else begin
          slot <= slot + 1'b1;
        end
      end
      if (rate_load) pend_lg <= LOG_W'(MIN_LOG2) + LOG_W'(rate_sel);
    end
  end
endmodule

// File: rtl/fsp_rx.sv
module fsp_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              fall,
  input  logic              sdi,
  input  logic              sifs,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);
  import fsp_pkg::*;
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  rx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      sh       <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!en) begin
        st  <= RX_IDLE;
        cnt <= '0;
      end else if (fall) begin
        if (st == RX_SHIFT) begin
          sh  <= {sh[WORD_W-2:0], sdi};
          cnt <= cnt + 1'b1;
          if (cnt == LAST_BIT) begin
            rx_valid <= 1'b1;
            rx_data  <= {sh[WORD_W-2:0], sdi};
            st       <= RX_IDLE;
          end
        end
        // a sync restarts the count, also in the middle of a word
        if (sifs) begin
          st  <= RX_SHIFT;
          cnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/fsync_serial_port.sv
module fsync_serial_port #(
  parameter int WORD_W    = 16,
  parameter int SCLK_HALF = 2,
  parameter int MIN_LOG2  = 7,
  parameter int DEF_LOG2  = 11,
  parameter int SEL_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [SEL_W-1:0]  rate_sel,
  input  logic              rate_load,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              sdi,
  input  logic              sifs,
  output logic              sclk,
  output logic              sofs,
  output logic              sdo,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int DIV_LOG2 = $clog2(2 * SCLK_HALF);

  logic rise, fall;

  fsp_sclk_gen #(.SCLK_HALF(SCLK_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(en),
    .sclk(sclk), .rise(rise), .fall(fall)
  );

  fsp_tx #(
    .WORD_W(WORD_W), .DIV_LOG2(DIV_LOG2), .MIN_LOG2(MIN_LOG2),
    .DEF_LOG2(DEF_LOG2), .SEL_W(SEL_W)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .en(en), .rise(rise),
    .rate_sel(rate_sel), .rate_load(rate_load),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .sofs(sofs), .sdo(sdo)
  );

  fsp_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(en), .fall(fall),
    .sdi(sdi), .sifs(sifs), .rx_data(rx_data), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/fsync_serial_port_chk.sv
module fsync_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic tx_ready,
  input logic sclk,
  input logic sofs,
  input logic sdo,
  input logic rx_valid
);
  // R10: disabled port goes quiet on the next cycle
  p_quiet_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sclk && !sofs && !sdo && !rx_valid));

  // R2: frame sync starts together with a serial clock rise
  p_fs_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sofs) |-> $rose(sclk));

  // R2: frame sync ends at the following rise while enabled
  p_fs_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sofs) && $past(en)) |-> $rose(sclk));

  // R2: data line moves only with a rising serial clock
  p_sdo_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sdo) && $past(en)) |-> $rose(sclk));

  // R7: receive strobe lasts a single cycle
  p_rx_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6: word request lasts a single cycle
  p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);

  // R1: clock never rises without enable
  p_sclk_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $past(en));
endmodule

bind fsync_serial_port fsync_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tx_ready(tx_ready), .sclk(sclk),
  .sofs(sofs), .sdo(sdo), .rx_valid(rx_valid)
);

// File: tb/fsync_serial_port_test.sv
`timescale 1ns/1ps
module fsync_serial_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = CLK_PERIOD / 4;
  localparam int W          = 16;
  localparam int HALF       = 2;
  localparam int DIV        = 4;
  localparam int MIN_LOG2   = 7;
  localparam int DEF_SLOTS  = 2048 / DIV;

  logic clk = 1'b0;
  logic rst_n, en, rate_load, tx_valid, sdi, sifs;
  logic [2:0] rate_sel;
  logic [W-1:0] tx_data;
  logic tx_ready, sclk, sofs, sdo, rx_valid;
  logic [W-1:0] rx_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsync_serial_port uut (
    .clk(clk), .rst_n(rst_n), .en(en), .rate_sel(rate_sel), .rate_load(rate_load),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .sdi(sdi), .sifs(sifs), .sclk(sclk), .sofs(sofs), .sdo(sdo),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  string tx_tag = "R3", rx_tag = "R7";
  logic [W-1:0] rx_exp[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // transmit source: pattern advances on each accepted word
  logic [7:0] tx_k = 8'h11;
  assign tx_data = {tx_k, ~tx_k};
  always @(posedge clk) if (tx_ready && tx_valid) tx_k <= tx_k + 8'h2B;

  // inputs as seen by the design at each edge
  logic c_rstn, c_en, c_load, c_txv, c_sifs;
  logic [2:0] c_sel;
  logic [W-1:0] c_txd;
  always @(posedge clk) begin
    cyc    <= cyc + 1;
    c_rstn <= rst_n; c_en <= en; c_load <= rate_load; c_sel <= rate_sel;
    c_txv  <= tx_valid; c_txd <= tx_data; c_sifs <= sifs;
  end

  // behavioural reference, stepped once per clock, compared mid-cycle
  int e = 0, nxt = 0, len = DEF_SLOTS, pend = DEF_SLOTS, rxn = -1, word = 0, ph;
  bit m_sclk = 0, m_sofs = 0, m_sdo = 0, m_rxv = 0, m_rdy;
  logic [W-1:0] want;
  always @(negedge clk) begin
    if (cyc > 0) begin
      if (!c_rstn) begin
        e = 0; nxt = 0; len = DEF_SLOTS; pend = DEF_SLOTS; rxn = -1;
        m_sclk = 0; m_sofs = 0; m_sdo = 0; m_rxv = 0;
      end else begin
        m_rxv = 0;
        if (!c_en) begin
          e = 0; nxt = 0; rxn = -1; m_sclk = 0; m_sofs = 0; m_sdo = 0;
        end else begin
          ph = e % DIV;
          e = e + 1;
          if (ph == 0) begin
            m_sclk = 1;
            m_sofs = (nxt == 0);
            if (nxt == 0) begin
              word = c_txv ? int'(c_txd) : 0;
              m_sdo = 0;
            end else if (nxt <= W) m_sdo = (word >> (W - nxt)) & 1;
            else m_sdo = 0;
            if (nxt == len - 1) begin nxt = 0; len = pend; end
            else nxt = nxt + 1;
          end else if (ph == HALF) begin
            m_sclk = 0;
            if (rxn >= 0) begin
              rxn = rxn + 1;
              if (rxn == W) begin m_rxv = 1; rxn = -1; end
            end
            if (c_sifs) rxn = 0;
          end
        end
        if (c_load) pend = (1 << (MIN_LOG2 + int'(c_sel))) / DIV;
      end
      m_rdy = rst_n && en && (e % DIV == 0) && (nxt == 0);
      chk(sclk == m_sclk, "R1", "sclk", sclk, m_sclk);
      chk(sofs == m_sofs, "R2", "sofs", sofs, m_sofs);
      chk(sdo == m_sdo, tx_tag, "sdo", sdo, m_sdo);
      chk(tx_ready == m_rdy, "R6", "tx_ready", tx_ready, m_rdy);
      chk(rx_valid == m_rxv, rx_tag, "rx_valid", rx_valid, m_rxv);
      if (m_rxv) begin
        want = (rx_exp.size() > 0) ? rx_exp.pop_front() : '0;
        chk(rx_data == want, rx_tag, "rx_data", rx_data, want);
      end
    end
  end

  // frame sync rise times
  int fs_cnt = 0, fs_last = 0, fs_prev = 0;
  logic sofs_d = 1'b0;
  always @(negedge clk) begin
    if (sofs && !sofs_d) begin fs_prev = fs_last; fs_last = cyc; fs_cnt++; end
    sofs_d = sofs;
  end

  task automatic wait_fs(input int n);
    int c0 = fs_cnt;
    wait (fs_cnt == c0 + n);
  endtask

  task automatic check_period(input int exp, input string req);
    wait_fs(2);
    chk(fs_last - fs_prev == exp, req, "frame period", fs_last - fs_prev, exp);
  endtask

  task automatic wait_rise();
    @(posedge sclk);
    #(Q);
  endtask

  // host serialiser: call just after a rise; drives one slot per serial clock
  task automatic host_word(input logic [W-1:0] w, input int nbits,
                           input bit lead_fs, input bit next_fs);
    if (nbits == W) rx_exp.push_back(w);
    if (lead_fs) begin sifs = 1'b1; sdi = 1'b0; wait_rise(); end
    for (int i = 0; i < nbits; i++) begin
      sdi  = w[W-1-i];
      sifs = next_fs && (i == nbits - 1);
      wait_rise();
    end
    sifs = 1'b0; sdi = 1'b0;
  endtask

  task automatic load_rate(input logic [2:0] code);
    @(posedge clk); #(Q);
    rate_sel = code; rate_load = 1'b1;
    @(posedge clk); #(Q);
    rate_load = 1'b0; rate_sel = 3'd5;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; rate_load = 1'b0; rate_sel = 3'd0;
    tx_valid = 1'b1; sdi = 1'b0; sifs = 1'b0;
    repeat (3) @(posedge clk);
    #(Q);
    // R10: reset state
    chk({sclk, sofs, sdo, rx_valid, tx_ready} == 5'b0, "R10", "reset outputs",
        {sclk, sofs, sdo, rx_valid, tx_ready}, 5'b0);
    chk(rx_data == '0, "R10", "reset rx_data", rx_data, 0);
    rst_n = 1'b1;
    repeat (20) @(posedge clk);
    #(Q);
    en = 1'b1;
    check_period(2048, "R4");

    // receive: aligned with the output frame sync
    rx_tag = "R7";
    @(posedge sofs); #(Q);
    host_word(16'hA5C3, W, 1'b1, 1'b0);
    // receive: lagging the output frames
    rx_tag = "R11";
    repeat (701) @(posedge clk);
    wait_rise();
    host_word(16'h1234, W, 1'b1, 1'b0);
    // receive: back to back
    rx_tag = "R8";
    repeat (33) @(posedge clk);
    wait_rise();
    host_word(16'hBEEF, W, 1'b1, 1'b1);
    host_word(16'h0F0F, W, 1'b0, 1'b1);
    host_word(16'h8001, W, 1'b0, 1'b0);
    // receive: early sync abandons a partial word
    rx_tag = "R9";
    repeat (40) @(posedge clk);
    wait_rise();
    host_word(16'hFFFF, 7, 1'b1, 1'b1);
    host_word(16'h5AA5, W, 1'b0, 1'b0);
    repeat (20) @(posedge clk);
    chk(rx_exp.size() == 0, "R7", "words left undelivered", rx_exp.size(), 0);

    // programmed rates
    load_rate(3'd0);
    wait_fs(1);
    check_period(128, "R5");
    tx_tag = "R6";
    #(Q); tx_valid = 1'b0;
    wait_fs(3);
    #(Q); tx_valid = 1'b1;
    wait_fs(2);
    tx_tag = "R3";
    load_rate(3'd2);
    wait_fs(1);
    check_period(512, "R5");

    // enable gap with host activity
    rx_tag = "R10";
    @(posedge clk); #(Q);
    en = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #(Q);
      sifs = (i % 19 == 3); sdi = i[0];
    end
    sifs = 1'b0; sdi = 1'b0;
    chk(rx_exp.size() == 0, "R10", "queue while idle", rx_exp.size(), 0);
    @(posedge clk); #(Q);
    en = 1'b1;
    check_period(512, "R10");

    // slowest code
    load_rate(3'd7);
    wait_fs(1);
    check_period(16384, "R5");
    repeat (10) @(posedge clk);
    finish_run();
  end
endmodule